// File: doc/BRIEF.md
# Two-Level Page-Table Walker with Split Single-Entry TLBs

This block turns a 32-bit virtual address into a 34-bit physical address for a processor core. Each request gives the virtual address, an access kind (instruction fetch, data load or data store) and the privilege level (user or supervisor). A translation base register sets three things: the mode (bare or translated), a 9-bit address-space tag, and the physical page number of the root table. When translation is on, the block first looks in one of two one-entry translation caches: the instruction cache serves fetches and the data cache serves loads and stores. On a miss it reads up to two 32-bit table entries through a memory read port whose data returns in the same cycle. It then answers with either a physical address or a page fault carrying a cause code. The block never writes the table. A clear accessed bit, or a clear dirty bit on a store, causes a fault so that software can update the entry.

The controller has four states. `ST_IDLE` waits for a request. From there it goes to `ST_DONE` on bare mode or a cache hit, and to `ST_L1` on a miss. `ST_L1` reads the first-level entry. It goes to `ST_L0` on a pointer entry, and to `ST_DONE` on a leaf (a 4 MiB megapage) or on a fault. `ST_L0` reads the second-level entry and always goes to `ST_DONE`. `ST_DONE` raises the response for exactly one cycle and returns to `ST_IDLE`. A fence input empties both caches.

Top module: `sv32_walker`

## Requirements
- R1: After reset, `resp_valid` and `mem_ren` are low and both translation caches are empty, so the first translated access performs a walk.
- R2: When `xlat_base[31]` is 0 (bare), an accepted request answers one cycle after acceptance with `resp_paddr = {2'b00, vaddr}`, no fault and no memory read, whatever either cache holds.
- R3: When `xlat_base[31]` is 1 and the cache misses, the first read is at `{xlat_base[21:0], vaddr[31:22], 2'b00}`. A pointer entry leads to a second read at `{pte[31:10], vaddr[21:12], 2'b00}`. A second-level leaf answers three cycles after acceptance with `{pte[31:10], vaddr[11:0]}`. Entry bits, from bit 7 down to bit 0, are D, A, G, U, X, W, R, V. Bits 9:8 are ignored.
- R4: A leaf found at the first level is a megapage. It answers two cycles after acceptance with `{pte[31:20], vaddr[21:0]}`. If `pte[19:10]` is nonzero, it faults instead.
- R5: An entry with V=0 at either level faults. A valid entry with R, W and X all zero is a pointer at the first level and faults at the second level. A leaf with W=1 and R=0 faults.
- R6: A leaf faults in any of these cases: a user access with U=0; A=0; a store with D=0; or the needed permission is clear (X for fetch, R for load, W for store).
- R7: The access kind is encoded 0 = fetch, 1 = load, 2 = store, and 3 behaves as a load. A fault reports cause 12 for a fetch, 13 for a load and 15 for a store.
- R8: A successful translation fills the cache for its access kind (instruction cache for fetch, data cache otherwise). A later hit answers one cycle after acceptance with no memory read. A hit applies the same checks as R6 to the cached bits. A faulting walk fills nothing.
- R9: A cache hit requires the entry's address-space tag to equal `xlat_base[30:22]`, unless the entry's G bit is set. A megapage entry matches on `vaddr[31:22]` alone.
- R10: A `fence` high for one cycle empties both caches. If the fence falls in the same cycle as a fill, the fence wins and the entry stays empty.
- R11: `resp_valid` is high for exactly one cycle per accepted request. A request is accepted only in `ST_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| req_user | input | 1 | 1 = user privilege, 0 = supervisor |
| xlat_base | input | 32 | Mode (bit 31), address-space tag (30:22), root page number (21:0) |
| fence | input | 1 | Empty both translation caches |
| mem_ren | output | 1 | Table read strobe |
| mem_addr | output | 34 | Table entry physical address |
| mem_rdata | input | 32 | Table entry, valid in the same cycle |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_fault | output | 1 | Page fault |
| resp_cause | output | 5 | Fault cause code |
| resp_paddr | output | 34 | Physical address (zero on a fault) |

## Verification
The fence and a cache fill can land on the same clock edge, because a fence may arrive while the walker is in `ST_L0` about to store a fresh translation. The bench provokes this by raising `fence` exactly in the `ST_L0` cycle of a walk. It then judges the result in two ways. The walk's own response must still be correct. The very next request to the same page must perform two table reads rather than hit. A third request without a fence must then hit, which shows that fills still work.

// File: rtl/sv32_pkg.sv
package sv32_pkg;

    localparam int VA_W    = 32;
    localparam int PA_W    = 34;
    localparam int PPN_W   = 22;
    localparam int VPN_W   = 20;
    localparam int ASID_W  = 9;
    localparam int OFF_W   = 12;
    localparam int CAUSE_W = 5;
    localparam int NUM_TLB = 2;
    localparam int TLB_I   = 0;
    localparam int TLB_D   = 1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_L1,
        ST_L0,
        ST_DONE
    } walk_state_t;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_t;

    typedef struct packed {
        logic [PPN_W-1:0] ppn;
        logic [1:0]       rsw;
        logic d, a, g, u, x, w, r, v;
    } pte_t;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic              mega;
        logic g, u, a, d, x, w, r;
        logic [PPN_W-1:0]  ppn;
    } tlb_ent_t;

    function automatic logic [CAUSE_W-1:0] fault_cause(acc_t kind);
        case (kind)
            ACC_FETCH: fault_cause = CAUSE_W'(12);
            ACC_STORE: fault_cause = CAUSE_W'(15);
            default:   fault_cause = CAUSE_W'(13);
        endcase
    endfunction

endpackage

// File: rtl/sv32_perm_check.sv
module sv32_perm_check
    import sv32_pkg::*;
(
    input  acc_t kind,
    input  logic user,
    input  logic u,
    input  logic a,
    input  logic d,
    input  logic x,
    input  logic w,
    input  logic r,
    output logic fault
);
    logic need_ok;

    always_comb begin
        unique case (kind)
            ACC_FETCH: need_ok = x;
            ACC_STORE: need_ok = w;
            default:   need_ok = r;
        endcase
        fault = (w & ~r) | (user & ~u) | ~a | ((kind == ACC_STORE) & ~d) | ~need_ok;
    end
endmodule

// File: rtl/sv32_tlb_slot.sv
module sv32_tlb_slot
    import sv32_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              fill,
    input  tlb_ent_t          fill_ent,
    input  logic [VPN_W-1:0]  look_vpn,
    input  logic [ASID_W-1:0] look_asid,
    output logic              hit,
    output tlb_ent_t          ent
);
    localparam int HALF = VPN_W / 2;

    logic valid_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            ent     <= '0;
        end else if (flush) begin
            valid_q <= 1'b0;
        end else if (fill) begin
            valid_q <= 1'b1;
            ent     <= fill_ent;
        end
    end

    always_comb begin
        hit = valid_q
            & (ent.g | (ent.asid == look_asid))
            & (ent.vpn[VPN_W-1:HALF] == look_vpn[VPN_W-1:HALF])
            & (ent.mega | (ent.vpn[HALF-1:0] == look_vpn[HALF-1:0]));
    end
endmodule

// File: rtl/sv32_walker.sv
module sv32_walker
    import sv32_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic [1:0]         req_acc,
    input  logic               req_user,
    input  logic [31:0]        xlat_base,
    input  logic               fence,
    output logic               mem_ren,
    output logic [PA_W-1:0]    mem_addr,
    input  logic [31:0]        mem_rdata,
    output logic               resp_valid,
    output logic               resp_fault,
    output logic [CAUSE_W-1:0] resp_cause,
    output logic [PA_W-1:0]    resp_paddr
);
    localparam int HALF = VPN_W / 2;
    localparam int MEGA_OFF = VA_W - HALF;

    walk_state_t state_q, state_d;

    logic [VA_W-1:0]  lat_va;
    acc_t             lat_acc;
    logic             lat_user;
    logic [31:0]      lat_base;
    logic [PPN_W-1:0] l1_ppn_q;

    logic               res_fault_q;
    logic [CAUSE_W-1:0] res_cause_q;
    logic [PA_W-1:0]    res_paddr_q;

    logic               take_res, nf;
    logic [PA_W-1:0]    npa;
    logic               fill_en;
    tlb_ent_t           fill_ent;

    logic [NUM_TLB-1:0] hit_v;
    tlb_ent_t           ent_v [NUM_TLB];
    int                 req_sel, lat_sel;

    pte_t     pte;
    tlb_ent_t hent;
    acc_t     chk_kind;
    logic     chk_user, chk_fault;

    assign pte     = pte_t'(mem_rdata);
    assign req_sel = (acc_t'(req_acc) == ACC_FETCH) ? TLB_I : TLB_D;
    assign lat_sel = (lat_acc == ACC_FETCH) ? TLB_I : TLB_D;
    assign hent    = ent_v[req_sel];

    genvar gi;
    generate
        for (gi = 0; gi < NUM_TLB; gi++) begin : g_slot
            sv32_tlb_slot i_slot (
                .clk      (clk),
                .rst_n    (rst_n),
                .flush    (fence),
                .fill     (fill_en && (lat_sel == gi)),
                .fill_ent (fill_ent),
                .look_vpn (req_vaddr[VA_W-1:OFF_W]),
                .look_asid(xlat_base[30:22]),
                .hit      (hit_v[gi]),
                .ent      (ent_v[gi])
            );
        end
    endgenerate

    // one checker serves both a cache hit (in IDLE) and a fetched leaf
    always_comb begin
        if (state_q == ST_IDLE) begin
            chk_kind = acc_t'(req_acc);
            chk_user = req_user;
        end else begin
            chk_kind = lat_acc;
            chk_user = lat_user;
        end
    end

    sv32_perm_check i_perm (
        .kind (chk_kind),
        .user (chk_user),
        .u    (state_q == ST_IDLE ? hent.u : pte.u),
        .a    (state_q == ST_IDLE ? hent.a : pte.a),
        .d    (state_q == ST_IDLE ? hent.d : pte.d),
        .x    (state_q == ST_IDLE ? hent.x : pte.x),
        .w    (state_q == ST_IDLE ? hent.w : pte.w),
        .r    (state_q == ST_IDLE ? hent.r : pte.r),
        .fault(chk_fault)
    );

    // next state and result selection
    always_comb begin
        state_d  = state_q;
        take_res = 1'b0;
        nf       = 1'b0;
        npa      = '0;
        fill_en  = 1'b0;
        fill_ent = '{vpn: lat_va[VA_W-1:OFF_W], asid: lat_base[30:22], mega: 1'b0,
                     g: pte.g, u: pte.u, a: pte.a, d: pte.d, x: pte.x, w: pte.w,
                     r: pte.r, ppn: pte.ppn};
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!xlat_base[31]) begin
                        state_d  = ST_DONE;
                        take_res = 1'b1;
                        npa      = {{(PA_W-VA_W){1'b0}}, req_vaddr};
                    end else if (hit_v[req_sel]) begin
                        state_d  = ST_DONE;
                        take_res = 1'b1;
                        nf       = chk_fault;
                        if (!chk_fault)
                            npa = hent.mega ? {hent.ppn[PPN_W-1:HALF], req_vaddr[MEGA_OFF-1:0]}
                                            : {hent.ppn, req_vaddr[OFF_W-1:0]};
                    end else begin
                        state_d = ST_L1;
                    end
                end
            end
            ST_L1: begin
                if (pte.v && !pte.r && !pte.w && !pte.x) begin
                    state_d = ST_L0;
                end else begin
                    state_d  = ST_DONE;
                    take_res = 1'b1;
                    nf       = !pte.v || chk_fault || (pte.ppn[HALF-1:0] != '0);
                    if (!nf) begin
                        fill_en       = 1'b1;
                        fill_ent.mega = 1'b1;
                        npa = {pte.ppn[PPN_W-1:HALF], lat_va[MEGA_OFF-1:0]};
                    end
                end
            end
            ST_L0: begin
                state_d  = ST_DONE;
                take_res = 1'b1;
                nf       = !pte.v || !(pte.r || pte.w || pte.x) || chk_fault;
                if (!nf) begin
                    fill_en = 1'b1;
                    npa     = {pte.ppn, lat_va[OFF_W-1:0]};
                end
            end
            ST_DONE: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            lat_va      <= '0;
            lat_acc     <= ACC_FETCH;
            lat_user    <= 1'b0;
            lat_base    <= '0;
            l1_ppn_q    <= '0;
            res_fault_q <= 1'b0;
            res_cause_q <= '0;
            res_paddr_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_valid) begin
                lat_va   <= req_vaddr;
                lat_acc  <= acc_t'(req_acc);
                lat_user <= req_user;
                lat_base <= xlat_base;
            end
            if (state_q == ST_L1)
                l1_ppn_q <= pte.ppn;
            if (take_res) begin
                res_fault_q <= nf;
                res_cause_q <= nf ? fault_cause(chk_kind) : '0;
                res_paddr_q <= npa;
            end
        end
    end

    // outputs
    always_comb begin
        resp_valid = (state_q == ST_DONE);
        resp_fault = res_fault_q;
        resp_cause = res_cause_q;
        resp_paddr = res_paddr_q;
        mem_ren    = (state_q == ST_L1) || (state_q == ST_L0);
        if (state_q == ST_L1)
            mem_addr = {lat_base[PPN_W-1:0], lat_va[VA_W-1:MEGA_OFF], 2'b00};
        else
            mem_addr = {l1_ppn_q, lat_va[MEGA_OFF-1:OFF_W], 2'b00};
    end

    assert_resp_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    assert_cause_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault) |->
            (resp_cause == ((lat_acc == ACC_FETCH) ? 5'd12 :
                            (lat_acc == ACC_STORE) ? 5'd15 : 5'd13)));

    assert_bare_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !lat_base[31]) |->
            (!resp_fault && resp_paddr == {{(PA_W-VA_W){1'b0}}, lat_va}));

    assert_fence_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fence |=> (hit_v == '0));

    assert_l0_after_l1_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_L0) |-> ($past(state_q) == ST_L1));

    assert_hit_noread_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && req_valid && xlat_base[31] && hit_v[req_sel]) |=> !mem_ren);

endmodule

// File: tb/test_sv32_walker.sv
module test_sv32_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic        req_user = 1'b0;
    logic [31:0] xlat_base = '0;
    logic        fence = 1'b0;
    logic        mem_ren;
    logic [33:0] mem_addr;
    logic [31:0] mem_rdata;
    logic        resp_valid, resp_fault;
    logic [4:0]  resp_cause;
    logic [33:0] resp_paddr;

    int nchk = 0;
    int nfail = 0;

    always #10 clk = ~clk;

    // sparse table memory: page select from address bits 13:12, word from 7:2
    logic [31:0] pmem [256];
    assign mem_rdata = pmem[{mem_addr[13:12], mem_addr[7:2]}];

    sv32_walker i_sv32_walker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_acc(req_acc), .req_user(req_user), .xlat_base(xlat_base), .fence(fence),
        .mem_ren(mem_ren), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_cause(resp_cause),
        .resp_paddr(resp_paddr)
    );

    typedef struct packed {
        logic [31:0] base;
        logic [31:0] va;
        logic [1:0]  typ;
        logic        user;
        logic        flt;
        logic [4:0]  cause;
        logic [33:0] pa;
        logic [1:0]  reads;
        logic [3:0]  req;
    } vec_t;

    localparam logic [31:0] BARE = 32'h0000_0100;
    localparam logic [31:0] AS1  = 32'h8040_0100;
    localparam logic [31:0] AS2  = 32'h8080_0100;
    localparam int NV = 24;

    localparam vec_t VECS [NV] = '{
        '{BARE, 32'h1234_5678, 2'd1, 1'b1, 1'b0, 5'd0,  34'h012345678, 2'd0, 4'd2},  // R2
        '{AS1,  32'h0040_0010, 2'd0, 1'b1, 1'b0, 5'd0,  34'h080001010, 2'd2, 4'd3},  // R3 R1
        '{AS1,  32'h0040_0ABC, 2'd0, 1'b1, 1'b0, 5'd0,  34'h080001ABC, 2'd0, 4'd8},  // R8 hit
        '{AS1,  32'h0040_0020, 2'd1, 1'b1, 1'b0, 5'd0,  34'h080001020, 2'd2, 4'd8},  // R8 split
        '{AS1,  32'h0040_0030, 2'd2, 1'b1, 1'b1, 5'd15, 34'h0,         2'd0, 4'd6},  // R6 no W on hit
        '{AS1,  32'h0040_1004, 2'd1, 1'b1, 1'b0, 5'd0,  34'h080002004, 2'd2, 4'd3},  // R3
        '{AS1,  32'h0040_1008, 2'd2, 1'b1, 1'b1, 5'd15, 34'h0,         2'd0, 4'd6},  // R6 D=0
        '{AS1,  32'h0040_2000, 2'd1, 1'b1, 1'b1, 5'd13, 34'h0,         2'd2, 4'd6},  // R6 U=0
        '{AS1,  32'h0040_2000, 2'd1, 1'b0, 1'b0, 5'd0,  34'h080003000, 2'd2, 4'd8},  // R8 no fill on fault
        '{AS1,  32'h0040_3000, 2'd1, 1'b0, 1'b1, 5'd13, 34'h0,         2'd2, 4'd6},  // R6 A=0
        '{AS1,  32'h0040_4000, 2'd0, 1'b1, 1'b1, 5'd12, 34'h0,         2'd2, 4'd5},  // R5 W&~R
        '{AS1,  32'h0040_5000, 2'd1, 1'b0, 1'b1, 5'd13, 34'h0,         2'd2, 4'd5},  // R5 pointer at L0
        '{AS1,  32'h0040_7000, 2'd3, 1'b0, 1'b1, 5'd13, 34'h0,         2'd2, 4'd7},  // R7 kind 3, R5 V=0
        '{AS1,  32'h0100_0000, 2'd1, 1'b0, 1'b1, 5'd13, 34'h0,         2'd1, 4'd5},  // R5 V=0 at L1
        '{AS1,  32'h0081_2345, 2'd2, 1'b1, 1'b0, 5'd0,  34'h000C12345, 2'd1, 4'd4},  // R4
        '{AS1,  32'h008F_F001, 2'd1, 1'b1, 1'b0, 5'd0,  34'h000CFF001, 2'd0, 4'd9},  // R9 mega hit, R4
        '{AS1,  32'h00C0_0000, 2'd1, 1'b1, 1'b1, 5'd13, 34'h0,         2'd1, 4'd4},  // R4 misaligned
        '{AS1,  32'h0040_8100, 2'd0, 1'b1, 1'b0, 5'd0,  34'h080009100, 2'd2, 4'd3},  // R3
        '{AS2,  32'h0040_8100, 2'd0, 1'b1, 1'b0, 5'd0,  34'h080009100, 2'd2, 4'd9},  // R9 asid miss
        '{AS2,  32'h0040_6040, 2'd1, 1'b0, 1'b0, 5'd0,  34'h080007040, 2'd2, 4'd3},  // R3 global page
        '{AS1,  32'h0040_6044, 2'd1, 1'b0, 1'b0, 5'd0,  34'h080007044, 2'd0, 4'd9},  // R9 G hit
        '{AS1,  32'h0040_6048, 2'd2, 1'b1, 1'b0, 5'd0,  34'h080007048, 2'd0, 4'd8},  // R8 store hit
        '{AS1,  32'h0040_6000, 2'd0, 1'b1, 1'b1, 5'd12, 34'h0,         2'd2, 4'd7},  // R7 fetch cause, R6 no X
        '{BARE, 32'h0040_6000, 2'd2, 1'b0, 1'b0, 5'd0,  34'h000406000, 2'd0, 4'd2}   // R2 ignores cache
    };

    task automatic chk(input bit ok, input int rq, input string what,
                       input logic [33:0] act, input logic [33:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic run(input logic [31:0] base, input logic [31:0] va, input logic [1:0] typ,
                       input logic user, input logic eflt, input logic [4:0] ecause,
                       input logic [33:0] epa, input int ereads, input int fence_at,
                       input int rq);
        int k = 0;
        int reads = 0;
        bit got = 0;
        logic f = 0;
        logic [4:0] c = 0;
        logic [33:0] p = 0;
        @(negedge clk);
        xlat_base = base; req_vaddr = va; req_acc = typ; req_user = user; req_valid = 1'b1;
        while (!got && k < 12) begin
            @(negedge clk);
            req_valid = 1'b0;
            k++;
            fence = (k == fence_at);
            if (mem_ren) reads++;
            if (resp_valid) begin
                got = 1; f = resp_fault; c = resp_cause; p = resp_paddr;
            end
        end
        @(negedge clk);
        fence = 1'b0;
        chk(resp_valid == 1'b0, 11, "response pulse width", 34'(resp_valid), 34'd0);
        chk(k == ereads + 1, rq, "latency", 34'(k), 34'(ereads + 1));
        chk(reads == ereads, rq, "table reads", 34'(reads), 34'(ereads));
        chk(f == eflt, rq, "fault", 34'(f), 34'(eflt));
        if (eflt) chk(c == ecause, rq, "cause", 34'(c), 34'(ecause));
        else      chk(p == epa, rq, "paddr", p, epa);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) pmem[i] = '0;
        // first-level table (root page 0x100, select 0)
        pmem[{2'd0, 6'd1}] = 32'h0004_0401;  // pointer to page 0x101
        pmem[{2'd0, 6'd2}] = 32'h0030_00DF;  // megapage 0xC00
        pmem[{2'd0, 6'd3}] = 32'h0030_04DF;  // misaligned megapage
        // second-level table (page 0x101, select 1)
        pmem[{2'd1, 6'd0}] = 32'h2000_04DB;  // user code
        pmem[{2'd1, 6'd1}] = 32'h2000_0857;  // user data, D=0
        pmem[{2'd1, 6'd2}] = 32'h2000_0CC7;  // supervisor page
        pmem[{2'd1, 6'd3}] = 32'h2000_1013;  // A=0
        pmem[{2'd1, 6'd4}] = 32'h2000_14D5;  // W without R
        pmem[{2'd1, 6'd5}] = 32'h0004_0401;  // pointer at second level
        pmem[{2'd1, 6'd6}] = 32'h2000_1CF7;  // global page, no X
        pmem[{2'd1, 6'd8}] = 32'h2000_24DF;  // all permissions

        repeat (3) @(negedge clk);
        // R1 reset state
        chk(resp_valid == 1'b0, 1, "resp_valid in reset", 34'(resp_valid), 34'd0);
        chk(mem_ren == 1'b0, 1, "mem_ren in reset", 34'(mem_ren), 34'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(resp_valid == 1'b0, 1, "resp_valid after reset", 34'(resp_valid), 34'd0);

        for (int v = 0; v < NV; v++)
            run(VECS[v].base, VECS[v].va, VECS[v].typ, VECS[v].user, VECS[v].flt,
                VECS[v].cause, VECS[v].pa, int'(VECS[v].reads), 0, int'(VECS[v].req));

        // R10 fence while idle: cached global page must be walked again
        run(AS1, 32'h0040_6044, 2'd1, 1'b0, 1'b0, 5'd0, 34'h080007044, 0, 0, 10);
        @(negedge clk); fence = 1'b1;
        @(negedge clk); fence = 1'b0;
        run(AS1, 32'h0040_6044, 2'd1, 1'b0, 1'b0, 5'd0, 34'h080007044, 2, 0, 10);

        // R10 fence in the same cycle as a fill (ST_L0 cycle): fence wins
        run(AS1, 32'h0040_1000, 2'd1, 1'b0, 1'b0, 5'd0, 34'h080002000, 2, 2, 10);
        run(AS1, 32'h0040_1010, 2'd1, 1'b0, 1'b0, 5'd0, 34'h080002010, 2, 0, 10);
        run(AS1, 32'h0040_1020, 2'd1, 1'b0, 1'b0, 5'd0, 34'h080002020, 0, 0, 10);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule